// File: doc/BRIEF.md
# Register Bank Pointer Address Generator

This block keeps the processor's 16-bit program status word and turns a general-purpose register reference into a data memory address. The upper five bits of the status word are the bank pointer. It picks one of 32 banks of eight byte-wide registers. The three bits below it are the direct bank pointer. The low byte carries the condition flags, which are stored as written and never computed here.

Software reaches the pointer fields in two ways. The move instructions use a full-width status port. Any data access uses a byte-wide bus port that answers at one fixed mirror address. The bank pointer and the low three op-code bits together form an address in the window 0x0100 to 0x01FF. That address is presented combinationally to the register file RAM, which lies outside this block.

Top module: `bank_addr_gen`

## Requirements
- R1: While reset is asserted and right after it is released, the whole status word reads 0x0000.
- R2: When the status write strobe is high at a clock edge, all 16 bits of the status word take the status write data. The new value is visible on the status read port after that edge.
- R3: The register address is 0x0100 + 8 × bank pointer + op-code[2:0]. The bank pointer is status bits 15..11. The address therefore always falls within 0x0100..0x01FF.
- R4: Op-code bits 7..3 have no effect on the register address.
- R5: A bus write to address 0x0078 loads write-data bits 7..3 into the bank pointer (status 15..11) and bits 2..0 into the direct bank pointer (status 10..8), both on the same edge.
- R6: A bus write to any address other than 0x0078 leaves the status word unchanged.
- R7: When the bus address is 0x0078, the bus read data equals status bits 15..8, the bank pointer above the direct bank pointer. At any other address it reads 0x00. Reading changes nothing.
- R8: When a status write and a mirror write fall in the same cycle, the status write alone takes effect.
- R9: A new bank pointer value drives the register address in the cycle right after the edge that wrote it.
- R10: The flag byte (status 7..0; from bit 7 down: half carry, interrupt enable, two interrupt level bits, negative, zero, overflow, carry) is changed only by status writes. Mirror writes leave it intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psWrEn | input | 1 | Status word write strobe |
| psWrData | input | 16 | Status word write data |
| psRdData | output | 16 | Current status word |
| busAddr | input | 16 | Data bus address |
| busWrEn | input | 1 | Data bus write strobe |
| busWrData | input | 8 | Data bus write data |
| busRdData | output | 8 | Mirror byte when the address matches, else zero |
| opcode | input | 8 | Current instruction op-code |
| regAddr | output | 16 | Generated register address |

## Verification
The bench builds the block with its default parameters: a 5-bit bank pointer, a 3-bit register select, a 16-bit address and the mirror at 0x0078. These values let a full sweep reach all 32 banks and all eight select codes, so the top and bottom of the 0x0100..0x01FF window are both exercised. They also let the sweep cover the mirror address and its immediate neighbours. Directed cycles target the write collision and the flag byte under mirror writes, and a long random stretch mixes both write paths against the behavioural model on every clock.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic psLoad;   // load the whole status word
    logic mirLoad;  // load the pointer fields from the bus byte
    logic mirRead;  // present the pointer byte on the bus
  } rbpStrobes_t;

endpackage

// File: rtl/rbp_ctrl.sv
module rbp_ctrl
  import rbp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 16'h0078
) (
  input  logic              psWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output rbpStrobes_t       strobes
);

  logic mirrorHit;

  assign mirrorHit = (busAddr == MIRROR_ADDR);

  always_comb begin
    strobes         = '0;
    strobes.psLoad  = psWrEn;
    // status word path takes priority over the byte mirror
    strobes.mirLoad = busWrEn && mirrorHit && !psWrEn;
    strobes.mirRead = mirrorHit;
  end

endmodule

// File: rtl/rbp_datapath.sv
module rbp_datapath
  import rbp_pkg::*;
#(
  parameter int BANK_W  = 5,
  parameter int DBANK_W = 3,
  parameter int CCR_W   = 8,
  parameter int SEL_W   = 3,
  parameter int OP_W    = 8,
  parameter int ADDR_W  = 16,
  localparam int PS_W     = BANK_W + DBANK_W + CCR_W,
  localparam int BYTE_W   = BANK_W + DBANK_W,
  localparam int PREFIX_W = ADDR_W - 1 - BANK_W - SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbpStrobes_t       strobes,
  input  logic [PS_W-1:0]   psWrData,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic [OP_W-1:0]   opcode,
  output logic [PS_W-1:0]   psRdData,
  output logic [BYTE_W-1:0] busRdData,
  output logic [ADDR_W-1:0] regAddr
);

  logic [BANK_W-1:0]  bankPtr;
  logic [DBANK_W-1:0] directPtr;
  logic [CCR_W-1:0]   flags;
  logic [SEL_W-1:0]   regSel;

  // Pointer fields: written by either path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankPtr   <= '0;
      directPtr <= '0;
    end else if (strobes.psLoad) begin
      bankPtr   <= psWrData[PS_W-1 -: BANK_W];
      directPtr <= psWrData[CCR_W +: DBANK_W];
    end else if (strobes.mirLoad) begin
      bankPtr   <= busWrData[BYTE_W-1 -: BANK_W];
      directPtr <= busWrData[DBANK_W-1:0];
    end
  end

  // Flag byte: written only through the status path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else if (strobes.psLoad) begin
      flags <= psWrData[CCR_W-1:0];
    end
  end

  assign psRdData  = {bankPtr, directPtr, flags};
  assign busRdData = strobes.mirRead ? {bankPtr, directPtr} : '0;
  assign regSel    = opcode[SEL_W-1:0];

  generate
    if (PREFIX_W > 0) begin : g_prefix
      assign regAddr = {{PREFIX_W{1'b0}}, 1'b1, bankPtr, regSel};
    end else begin : g_noPrefix
      assign regAddr = {1'b1, bankPtr, regSel};
    end
  endgenerate

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import rbp_pkg::*;
#(
  parameter int BANK_W  = 5,
  parameter int DBANK_W = 3,
  parameter int CCR_W   = 8,
  parameter int SEL_W   = 3,
  parameter int OP_W    = 8,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 16'h0078
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              psWrEn,
  input  logic [BANK_W+DBANK_W+CCR_W-1:0]   psWrData,
  output logic [BANK_W+DBANK_W+CCR_W-1:0]   psRdData,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic                              busWrEn,
  input  logic [BANK_W+DBANK_W-1:0]         busWrData,
  output logic [BANK_W+DBANK_W-1:0]         busRdData,
  input  logic [OP_W-1:0]                   opcode,
  output logic [ADDR_W-1:0]                 regAddr
);

  rbpStrobes_t strobes;

  rbp_ctrl #(
    .ADDR_W      (ADDR_W),
    .MIRROR_ADDR (MIRROR_ADDR)
  ) u_ctrl (
    .psWrEn  (psWrEn),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  rbp_datapath #(
    .BANK_W  (BANK_W),
    .DBANK_W (DBANK_W),
    .CCR_W   (CCR_W),
    .SEL_W   (SEL_W),
    .OP_W    (OP_W),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .psWrData  (psWrData),
    .busWrData (busWrData),
    .opcode    (opcode),
    .psRdData  (psRdData),
    .busRdData (busRdData),
    .regAddr   (regAddr)
  );

endmodule

// File: rtl/bank_addr_gen_chk.sv
module bank_addr_gen_chk #(
  parameter int PS_W   = 16,
  parameter int BYTE_W = 8,
  parameter int OP_W   = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 16'h0078
) (
  input logic              clk,
  input logic              rstN,
  input logic              psWrEn,
  input logic [PS_W-1:0]   psWrData,
  input logic [PS_W-1:0]   psRdData,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [BYTE_W-1:0] busWrData,
  input logic [BYTE_W-1:0] busRdData,
  input logic [OP_W-1:0]   opcode,
  input logic [ADDR_W-1:0] regAddr
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> psRdData == '0);

  p_ps_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    psWrEn |=> psRdData == $past(psWrData));

  p_addr_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == {8'h01, psRdData[15:11], opcode[2:0]});

  p_mirror_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!psWrEn && busWrEn && busAddr == MIRROR_ADDR) |=>
      psRdData[15:8] == $past(busWrData));

  p_other_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!psWrEn && !(busWrEn && busAddr == MIRROR_ADDR)) |=> $stable(psRdData));

  p_mirror_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    busRdData == ((busAddr == MIRROR_ADDR) ? psRdData[15:8] : '0));

  p_collision_r8: assert property (@(posedge clk) disable iff (!rstN)
    (psWrEn && busWrEn && busAddr == MIRROR_ADDR) |=>
      psRdData == $past(psWrData));

  p_flags_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    !psWrEn |=> psRdData[7:0] == $past(psRdData[7:0]));

endmodule

bind bank_addr_gen bank_addr_gen_chk #(
  .PS_W        (BANK_W + DBANK_W + CCR_W),
  .BYTE_W      (BANK_W + DBANK_W),
  .OP_W        (OP_W),
  .ADDR_W      (ADDR_W),
  .MIRROR_ADDR (MIRROR_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .psWrEn    (psWrEn),
  .psWrData  (psWrData),
  .psRdData  (psRdData),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .opcode    (opcode),
  .regAddr   (regAddr)
);

// File: tb/bank_addr_gen_bench.sv
module bank_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psWrEn = 1'b0;
  logic [15:0] psWrData = '0;
  logic [15:0] psRdData;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [7:0]  opcode = '0;
  logic [15:0] regAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] modelPs = '0;

  always #5 clk = ~clk;

  bank_addr_gen u_bank_addr_gen (
    .clk       (clk),
    .rstN      (rstN),
    .psWrEn    (psWrEn),
    .psWrData  (psWrData),
    .psRdData  (psRdData),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .opcode    (opcode),
    .regAddr   (regAddr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, compare against the model,
  // then advance the model over the rising edge.
  task automatic step(input logic pw, input logic [15:0] pd, input logic [15:0] ba,
                      input logic bw, input logic [7:0] bd, input logic [7:0] op,
                      input string tagPs, input string tagAddr);
    logic [15:0] expAddr;
    logic [7:0]  expBus;
    @(negedge clk);
    psWrEn = pw; psWrData = pd; busAddr = ba; busWrEn = bw; busWrData = bd; opcode = op;
    #1;
    expAddr = 16'h0100 + 16'(modelPs[15:11]) * 16'd8 + 16'(op % 8);
    expBus  = (ba == 16'h0078) ? modelPs[15:8] : 8'h00;
    check(tagPs, psRdData, modelPs);
    check(tagAddr, regAddr, expAddr);
    check("R7", {8'h00, busRdData}, {8'h00, expBus});
    @(posedge clk);
    if (pw) modelPs = pd;
    else if (bw && ba == 16'h0078) modelPs[15:8] = bd;
  endtask

  task automatic idle(input logic [7:0] op, input string tagPs, input string tagAddr);
    step(1'b0, 16'h0, 16'h0000, 1'b0, 8'h00, op, tagPs, tagAddr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    opcode = 8'h05;
    #1;
    check("R1", psRdData, 16'h0000);
    check("R1", regAddr, 16'h0105);
    rstN = 1'b1;
    idle(8'h02, "R1", "R1");

    // R2: whole-word write, then R9: address follows next cycle
    step(1'b1, 16'hA5C3, 16'h0000, 1'b0, 8'h00, 8'h01, "R2", "R3");
    idle(8'h07, "R2", "R9");

    // R6: writes beside the mirror address are ignored
    step(1'b0, 16'h0, 16'h0079, 1'b1, 8'hFF, 8'h00, "R6", "R3");
    step(1'b0, 16'h0, 16'h0077, 1'b1, 8'h00, 8'h00, "R6", "R3");
    step(1'b0, 16'h0, 16'h0178, 1'b1, 8'h11, 8'h00, "R6", "R3");
    idle(8'h00, "R6", "R3");

    // R7: reading the mirror has no side effect
    step(1'b0, 16'h0, 16'h0078, 1'b0, 8'h00, 8'h03, "R7", "R3");
    step(1'b0, 16'h0, 16'h0078, 1'b0, 8'h00, 8'h03, "R7", "R3");

    // R5, R10: mirror write changes pointers, leaves flags
    step(1'b0, 16'h0, 16'h0078, 1'b1, 8'h5A, 8'h04, "R5", "R3");
    idle(8'h04, "R10", "R9");
    step(1'b1, 16'h00FF, 16'h0000, 1'b0, 8'h00, 8'h00, "R2", "R3");
    step(1'b0, 16'h0, 16'h0078, 1'b1, 8'hFF, 8'h00, "R5", "R3");
    idle(8'h06, "R10", "R9");

    // R8: collision, status word wins
    step(1'b1, 16'h1234, 16'h0078, 1'b1, 8'hEE, 8'h00, "R8", "R3");
    idle(8'h00, "R8", "R9");

    // R3, R4: sweep all banks and selects, with upper op-code bits set
    for (int b = 0; b < 32; b++) begin
      step(1'b0, 16'h0, 16'h0078, 1'b1, 8'(b * 8), 8'h00, "R5", "R3");
      for (int s = 0; s < 8; s++) begin
        idle(8'((s * 37 + b * 8) & 8'hF8) | 8'(s), "R5", "R4");
      end
    end

    // Random mix of both write paths
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = ($urandom_range(0, 2) == 0) ? 16'h0078 : 16'($urandom);
      step($urandom_range(0, 3) == 0, 16'($urandom), a, $urandom_range(0, 1) == 1,
           8'($urandom), 8'($urandom), "R2", "R3");
    end
    idle(8'h00, "R2", "R3");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule